// File: doc/BRIEF.md
# I2C Slave Transmitter with Clock Stretching

This block is the transmit side of a two-wire (I2C) slave. It watches the synchronized clock and data lines for START, repeated START and STOP conditions. It then collects a 7-bit address followed by the read/write bit and compares the address with its own. When the master asks to read from this slave, the block acknowledges the address. It then sends bytes most significant bit first and samples the master's acknowledge after each byte.

Software provides data through a single-byte holding register, using a write strobe and a data byte. When the slave needs the next byte, it moves the held byte into its shift register. If no fresh byte is waiting at that moment, the slave pulls the clock line low after the acknowledge bit and raises a clock-wait flag. It keeps the clock low until software writes a byte. Status flags report the following: the holding register may be refilled, a read transfer has finished, the slave has been addressed, and the direction of that access.

Top module: `i2cst_slave_tx`

## Requirements
- R1: After reset, tx_ready_o is 1, tx_done_o, slv_access_o, slv_read_o and clk_wait_o are 0, and neither bus line is pulled low.
- R2: After a START, the slave samples the address MSB first on rising SCL, followed by the R/W bit (1 means read). If the address equals OWN_ADDR and R/W is 1, the slave pulls SDA low for the ninth clock and sets slv_access_o and slv_read_o. If the address does not match, the slave sends no acknowledge and slv_access_o stays 0.
- R3: If the address matches and R/W is 0, slv_access_o is set and slv_read_o is 0, and no acknowledge is given.
- R4: Data bytes go out MSB first. SDA is changed only while SCL is low, so it is stable for the whole high phase.
- R5: tx_ready_o falls when the held byte is copied into the shift register. It rises when the master's acknowledge bit for that byte is sampled, whether that bit is an ACK or a NACK.
- R6: If no unsent byte is held when the next byte is needed after an acknowledge, the slave holds SCL low and sets clk_wait_o. A write then releases SCL, clears clk_wait_o and sends the written byte.
- R7: A byte written while an earlier byte is being sent, or while no transfer is active, is kept. It becomes the next byte sent, and no stretching occurs.
- R8: After a NACK (SDA high in the acknowledge bit), the slave releases SDA and SCL and sends nothing more, even if a byte is held.
- R9: A STOP that ends a read sets tx_done_o. A new matching read address clears it.
- R10: A repeated START followed by a non-matching address ends an active read and sets tx_done_o. A repeated START followed by the own address with R/W set continues the read, and tx_done_o stays 0.
- R11: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Both clear slv_access_o and slv_read_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level as seen on the bus |
| sda_i | input | 1 | SDA level as seen on the bus |
| scl_pull_o | output | 1 | 1 pulls SCL low (stretching) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_byte_i | input | BYTE_W | Byte written to the holding register |
| tx_ready_o | output | 1 | Holding register may take a new byte |
| tx_done_o | output | 1 | Read transfer complete |
| slv_read_o | output | 1 | R/W bit of the matched address |
| slv_access_o | output | 1 | Slave addressed since the last START |
| clk_wait_o | output | 1 | Clock is being stretched |

## Verification
The bench builds the block with BYTE_W 8, ADDR_W 7, SYNC_STAGES 2 and OWN_ADDR 7'h33. This address has zeros and ones at both ends, so a reversed bit order or a shifted compare makes the address fail to match. The foreign addresses differ from it in only the top bit or only the bottom bit, which tests the compare at both ends. A bus half-period of eight clocks is longer than the detection delay of the two synchronizer stages plus the edge register, so the slave's pull on the clock is in place before the master tries to release it. This makes stretch and no-stretch sequences repeatable, with random data and random byte counts.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR    = 3'd1,
        ST_AACK    = 3'd2,
        ST_TX      = 3'd3,
        ST_DACK    = 3'd4,
        ST_STRETCH = 3'd5
    } state_e;

endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] pipe_d [STAGES];
    logic [W-1:0] pipe_q [STAGES];

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    // idle bus lines are high, so the chain resets high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= '1;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/i2cst_cond.sv
module i2cst_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s_i;
        prev_d.sda = sda_s_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign scl_rise_o = scl_s_i & ~prev_q.scl;
    assign scl_fall_o = ~scl_s_i & prev_q.scl;
    // data edges only count while the clock stayed high across both samples
    assign start_o    = scl_s_i & prev_q.scl & prev_q.sda & ~sda_s_i;
    assign stop_o     = scl_s_i & prev_q.scl & ~prev_q.sda & sda_s_i;

    p_no_cond_on_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o || stop_o) |-> $past(scl_s_i))
        else $error("bus condition flagged without SCL high before");

endmodule

// File: rtl/i2cst_hold.sv
module i2cst_hold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic              take_i,
    output logic [BYTE_W-1:0] hold_data_o,
    output logic              hold_vld_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              vld;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take_i) begin
            hold_d.vld = 1'b0;
        end
        // a write in the same cycle as a take is a fresh byte and wins
        if (wr_en_i) begin
            hold_d.data = wr_byte_i;
            hold_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign hold_data_o = hold_q.data;
    assign hold_vld_o  = hold_q.vld;

    p_hold_keeps_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en_i) |-> $stable(hold_data_o))
        else $error("held byte changed without a write");

    p_take_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(take_i) && !$past(wr_en_i)) |-> !hold_vld_o)
        else $error("held byte still marked valid after transfer");

endmodule

// File: rtl/i2cst_fsm.sv
module i2cst_fsm
    import i2cst_pkg::*;
#(
    parameter int                BYTE_W   = 8,
    parameter int                ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s_i,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              hold_vld_i,
    input  logic [BYTE_W-1:0] hold_data_i,
    output logic              take_o,
    output logic              scl_pull_o,
    output logic              sda_pull_o,
    output logic              tx_ready_o,
    output logic              tx_done_o,
    output logic              slv_read_o,
    output logic              slv_access_o,
    output logic              clk_wait_o
);

    localparam int FRAME = ADDR_W + 1;
    localparam int MAXB  = (FRAME > BYTE_W) ? FRAME : BYTE_W;
    localparam int CNT_W = $clog2(MAXB + 1);

    typedef struct packed {
        state_e             st;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME-1:0]   adr;
        logic [BYTE_W-1:0]  sh;
        logic               sda_pull;
        logic               scl_pull;
        logic               tx_ready;
        logic               tx_done;
        logic               slv_read;
        logic               slv_access;
        logic               clk_wait;
        logic               rd_act;
        logic               acked;
    } fsm_t;

    fsm_t nxt_d, cur_q;
    logic need_byte;

    always_comb begin
        nxt_d     = cur_q;
        need_byte = 1'b0;
        take_o    = 1'b0;
        if (stop_i) begin
            if (cur_q.rd_act) begin
                nxt_d.tx_done = 1'b1;
            end
            nxt_d.rd_act     = 1'b0;
            nxt_d.st         = ST_IDLE;
            nxt_d.sda_pull   = 1'b0;
            nxt_d.scl_pull   = 1'b0;
            nxt_d.slv_access = 1'b0;
            nxt_d.slv_read   = 1'b0;
        end else if (start_i) begin
            nxt_d.st         = ST_ADDR;
            nxt_d.cnt        = '0;
            nxt_d.sda_pull   = 1'b0;
            nxt_d.scl_pull   = 1'b0;
            nxt_d.slv_access = 1'b0;
            nxt_d.slv_read   = 1'b0;
        end else begin
            unique case (cur_q.st)
                ST_ADDR: begin
                    if (scl_rise_i && cur_q.cnt != CNT_W'(FRAME)) begin
                        nxt_d.adr = {cur_q.adr[FRAME-2:0], sda_s_i};
                        nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                    end else if (scl_fall_i && cur_q.cnt == CNT_W'(FRAME)) begin
                        if (cur_q.adr[FRAME-1:1] == OWN_ADDR) begin
                            nxt_d.slv_access = 1'b1;
                            nxt_d.slv_read   = cur_q.adr[0];
                            nxt_d.tx_done    = 1'b0;
                            nxt_d.clk_wait   = 1'b0;
                            if (cur_q.adr[0]) begin
                                nxt_d.rd_act   = 1'b1;
                                nxt_d.sda_pull = 1'b1;
                                nxt_d.st       = ST_AACK;
                            end else begin
                                nxt_d.rd_act = 1'b0;
                                nxt_d.st     = ST_IDLE;
                            end
                        end else begin
                            if (cur_q.rd_act) begin
                                nxt_d.tx_done = 1'b1;
                            end
                            nxt_d.rd_act = 1'b0;
                            nxt_d.st     = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall_i) begin
                        nxt_d.sda_pull = 1'b0;
                        need_byte      = 1'b1;
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (cur_q.cnt == CNT_W'(BYTE_W - 1)) begin
                            nxt_d.sda_pull = 1'b0;
                            nxt_d.st       = ST_DACK;
                        end else begin
                            nxt_d.sh       = cur_q.sh << 1;
                            nxt_d.cnt      = cur_q.cnt + CNT_W'(1);
                            nxt_d.sda_pull = ~cur_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_DACK: begin
                    if (scl_rise_i) begin
                        nxt_d.acked    = ~sda_s_i;
                        nxt_d.tx_ready = 1'b1;
                    end else if (scl_fall_i) begin
                        if (cur_q.acked) begin
                            need_byte = 1'b1;
                        end else begin
                            nxt_d.st = ST_IDLE;
                        end
                    end
                end
                ST_STRETCH: begin
                    if (hold_vld_i) begin
                        need_byte      = 1'b1;
                        nxt_d.clk_wait = 1'b0;
                        nxt_d.tx_done  = 1'b0;
                    end
                end
                default: begin
                end
            endcase
        end

        // next byte is due: load it, or hold the clock until one arrives
        if (need_byte) begin
            if (hold_vld_i) begin
                take_o         = 1'b1;
                nxt_d.sh       = hold_data_i;
                nxt_d.cnt      = '0;
                nxt_d.sda_pull = ~hold_data_i[BYTE_W-1];
                nxt_d.scl_pull = 1'b0;
                nxt_d.tx_ready = 1'b0;
                nxt_d.st       = ST_TX;
            end else begin
                nxt_d.sda_pull = 1'b0;
                nxt_d.scl_pull = 1'b1;
                nxt_d.clk_wait = 1'b1;
                nxt_d.st       = ST_STRETCH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q          <= '0;
            cur_q.st       <= ST_IDLE;
            cur_q.tx_ready <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign scl_pull_o   = cur_q.scl_pull;
    assign sda_pull_o   = cur_q.sda_pull;
    assign tx_ready_o   = cur_q.tx_ready;
    assign tx_done_o    = cur_q.tx_done;
    assign slv_read_o   = cur_q.slv_read;
    assign slv_access_o = cur_q.slv_access;
    assign clk_wait_o   = cur_q.clk_wait;

    logic in_aack, in_dack, acked_q;
    assign in_aack = (cur_q.st == ST_AACK);
    assign in_dack = (cur_q.st == ST_DACK);
    assign acked_q = cur_q.acked;

    p_ack_drives_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_aack |-> (sda_pull_o && slv_read_o))
        else $error("address acknowledge not driven for a read match");

    p_read_needs_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slv_read_o |-> slv_access_o)
        else $error("read flag without access flag");

    p_sda_moves_low_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_s_i))
        else $error("SDA changed while SCL high");

    p_ready_falls_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready_o) |-> $past(hold_vld_i))
        else $error("ready cleared without a held byte");

    p_stretch_flagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull_o |-> clk_wait_o)
        else $error("clock held without clock-wait flag");

    p_nack_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_dack) && $past(scl_fall_i) && !$past(acked_q) && !$past(start_i) && !$past(stop_i))
        |-> (!sda_pull_o && !scl_pull_o))
        else $error("lines not released after NACK");

    p_done_not_stretching_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done_o && scl_pull_o))
        else $error("transfer complete while stretching");

endmodule

// File: rtl/i2cst_slave_tx.sv
module i2cst_slave_tx #(
    parameter int                BYTE_W      = 8,
    parameter int                ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] OWN_ADDR    = 7'h5A,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull_o,
    output logic              sda_pull_o,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    output logic              tx_ready_o,
    output logic              tx_done_o,
    output logic              slv_read_o,
    output logic              slv_access_o,
    output logic              clk_wait_o
);

    localparam int LINES = 2;

    logic [LINES-1:0] bus_s;
    logic             scl_s, sda_s;
    logic             scl_rise, scl_fall, start_det, stop_det;
    logic             take;
    logic             hold_vld;
    logic [BYTE_W-1:0] hold_data;

    i2cst_sync #(
        .STAGES (SYNC_STAGES),
        .W      (LINES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (bus_s)
    );

    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    i2cst_cond i_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s_i    (scl_s),
        .sda_s_i    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2cst_hold #(
        .BYTE_W (BYTE_W)
    ) i_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_byte_i   (wr_byte_i),
        .take_i      (take),
        .hold_data_o (hold_data),
        .hold_vld_o  (hold_vld)
    );

    i2cst_fsm #(
        .BYTE_W   (BYTE_W),
        .ADDR_W   (ADDR_W),
        .OWN_ADDR (OWN_ADDR)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_s_i      (scl_s),
        .sda_s_i      (sda_s),
        .scl_rise_i   (scl_rise),
        .scl_fall_i   (scl_fall),
        .start_i      (start_det),
        .stop_i       (stop_det),
        .hold_vld_i   (hold_vld),
        .hold_data_i  (hold_data),
        .take_o       (take),
        .scl_pull_o   (scl_pull_o),
        .sda_pull_o   (sda_pull_o),
        .tx_ready_o   (tx_ready_o),
        .tx_done_o    (tx_done_o),
        .slv_read_o   (slv_read_o),
        .slv_access_o (slv_access_o),
        .clk_wait_o   (clk_wait_o)
    );

endmodule

// File: tb/test_i2cst_slave_tx.sv
module test_i2cst_slave_tx;

    localparam int         H  = 8;
    localparam logic [6:0] ME = 7'h33;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic m_scl_low = 1'b0;
    logic m_sda_low = 1'b0;
    logic scl_pull, sda_pull;
    logic scl_line, sda_line;
    logic wr_en = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic tx_ready, tx_done, slv_read, slv_access, clk_wait;

    assign scl_line = !(m_scl_low || scl_pull);
    assign sda_line = !(m_sda_low || sda_pull);

    i2cst_slave_tx #(
        .BYTE_W      (8),
        .ADDR_W      (7),
        .OWN_ADDR    (ME),
        .SYNC_STAGES (2)
    ) i_i2cst_slave_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_line),
        .sda_i        (sda_line),
        .scl_pull_o   (scl_pull),
        .sda_pull_o   (sda_pull),
        .wr_en_i      (wr_en),
        .wr_byte_i    (wr_byte),
        .tx_ready_o   (tx_ready),
        .tx_done_o    (tx_done),
        .slv_read_o   (slv_read),
        .slv_access_o (slv_access),
        .clk_wait_o   (clk_wait)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit stretch_pending = 1'b0;
    logic [7:0] pend_byte = 8'h00;
    logic [7:0] txd [4];
    bit         txm [4];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] b);
        wr_en   = 1'b1;
        wr_byte = b;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // release SCL and wait for the line; serve a stretch request if one is expected
    task automatic scl_up();
        m_scl_low = 1'b0;
        @(negedge clk);
        while (!scl_line) begin
            if (stretch_pending && clk_wait) begin
                chk("R6 stretch holds SCL", scl_pull, 1'b1);
                do_write(pend_byte);
                stretch_pending = 1'b0;
                wt(2);
                chk("R6 clk_wait clears after write", clk_wait, 1'b0);
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic wr_bit(input logic b);
        m_sda_low = !b;
        wt(H);
        scl_up();
        wt(H);
        m_scl_low = 1'b1;
        wt(H);
    endtask

    task automatic rd_bit(output logic b);
        logic b_end;
        m_sda_low = 1'b0;
        wt(H);
        scl_up();
        wt(H / 2);
        b = sda_line;
        wt(H / 2);
        b_end = sda_line;
        chk("R4 SDA stable while SCL high", b_end, b);
        m_scl_low = 1'b1;
        wt(H);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0;
        wt(H);
        scl_up();
        wt(H);
        m_sda_low = 1'b1;
        wt(H);
        m_scl_low = 1'b1;
        wt(H);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1;
        wt(H);
        scl_up();
        wt(H);
        m_sda_low = 1'b0;
        wt(H);
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rw, output logic ackbit);
        for (int i = 6; i >= 0; i--) begin
            wr_bit(a[i]);
        end
        wr_bit(rw);
        rd_bit(ackbit);
    endtask

    // reads one byte; pre-arranges the following byte after the first bit
    task automatic rd_byte(input bit ack, input bit arrange, input logic [7:0] nb,
                           input bit nb_pre, output logic [7:0] got);
        logic b;
        got = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            rd_bit(b);
            got[i] = b;
            if (i == 7 && arrange) begin
                if (nb_pre) begin
                    do_write(nb);
                end else begin
                    pend_byte       = nb;
                    stretch_pending = 1'b1;
                end
            end
            if (i == 4) begin
                chk("R5 tx_ready low while byte in flight", tx_ready, 1'b0);
            end
        end
        m_sda_low = ack;
        wt(H);
        scl_up();
        wt(H);
        chk("R5 tx_ready set after acknowledge bit", tx_ready, 1'b1);
        m_scl_low = 1'b1;
        wt(H);
        m_sda_low = 1'b0;
    endtask

    // read transaction of len bytes from txd/txm; first_held: byte 0 already held
    task automatic read_txn(input int len, input bit first_held, input bit do_start);
        logic ackbit;
        logic [7:0] got;
        if (!first_held) begin
            if (txm[0]) do_write(txd[0]);
            else begin
                pend_byte       = txd[0];
                stretch_pending = 1'b1;
            end
        end
        if (do_start) m_start();
        send_addr(ME, 1'b1, ackbit);
        chk("R2 own read address acknowledged", ackbit, 1'b0);
        chk("R2 slv_access on match", slv_access, 1'b1);
        chk("R2 slv_read on read match", slv_read, 1'b1);
        chk("R9 tx_done cleared by matching read", tx_done, 1'b0);
        for (int k = 0; k < len; k++) begin
            rd_byte(k < len - 1, k < len - 1, (k < len - 1) ? txd[k+1] : 8'h00,
                    (k < len - 1) ? txm[k+1] : 1'b1, got);
            chk($sformatf("R4 data byte %0d", k), got, txd[k]);
        end
        chk("R6 every stretch served", stretch_pending, 1'b0);
    endtask

    initial begin
        logic ackbit;
        logic [7:0] got;
        wt(3);
        // R1 reset state
        chk("R1 tx_ready", tx_ready, 1'b1);
        chk("R1 tx_done", tx_done, 1'b0);
        chk("R1 slv_access", slv_access, 1'b0);
        chk("R1 slv_read", slv_read, 1'b0);
        chk("R1 clk_wait", clk_wait, 1'b0);
        chk("R1 pulls", {scl_pull, sda_pull}, 2'b00);
        rst_n = 1'b1;
        wt(4);
        chk("R1 lines idle after reset", {scl_pull, sda_pull}, 2'b00);
        m_scl_low = 1'b0;

        // R2 foreign address (top bit differs): no acknowledge
        m_start();
        send_addr(ME ^ 7'h40, 1'b1, ackbit);
        chk("R2 foreign address not acknowledged", ackbit, 1'b1);
        chk("R2 slv_access stays low", slv_access, 1'b0);
        m_stop();
        chk("R9 no tx_done without read", tx_done, 1'b0);

        // R3 own address, write direction
        m_start();
        send_addr(ME, 1'b0, ackbit);
        chk("R3 write request not acknowledged", ackbit, 1'b1);
        chk("R3 slv_access set", slv_access, 1'b1);
        chk("R3 slv_read clear", slv_read, 1'b0);
        m_stop();
        chk("R11 STOP clears slv_access", slv_access, 1'b0);

        // R4 R6 R7 R9: preloaded byte, then a stretched byte
        txd[0] = 8'hA5; txm[0] = 1'b1;
        txd[1] = 8'h3C; txm[1] = 1'b0;
        read_txn(2, 1'b0, 1'b1);
        chk("R9 tx_done low before STOP", tx_done, 1'b0);
        m_stop();
        chk("R9 tx_done after STOP", tx_done, 1'b1);

        // R8: NACK then a byte written; slave stays off the bus
        txd[0] = 8'h81; txm[0] = 1'b1;
        read_txn(1, 1'b0, 1'b1);
        do_write(8'h7E);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if ({scl_pull, sda_pull} != 2'b00)
                chk("R8 lines released after NACK", {scl_pull, sda_pull}, 2'b00);
        end
        chk("R8 lines released after NACK", {scl_pull, sda_pull}, 2'b00);
        // R10 repeated start to a foreign address (bottom bit differs)
        m_start();
        chk("R11 START clears slv_access", slv_access, 1'b0);
        send_addr(ME ^ 7'h01, 1'b1, ackbit);
        chk("R10 foreign address after restart not acked", ackbit, 1'b1);
        chk("R10 tx_done after foreign restart", tx_done, 1'b1);
        m_stop();

        // R7 byte kept from before; R10 matching restart continues
        txd[0] = 8'h7E; txm[0] = 1'b1;
        read_txn(1, 1'b1, 1'b1);
        chk("R7 hold byte sent without stretch", clk_wait, 1'b0);
        txd[0] = 8'h5C; txm[0] = 1'b1;
        txd[1] = 8'h02; txm[1] = 1'b1;
        read_txn(2, 1'b0, 1'b1);
        chk("R10 matching restart keeps tx_done low", tx_done, 1'b0);
        m_stop();
        chk("R9 tx_done after STOP", tx_done, 1'b1);

        // random transactions
        void'($urandom(32'h1C2B));
        for (int t = 0; t < 25; t++) begin
            int len;
            len = 1 + int'($urandom % 4);
            for (int k = 0; k < 4; k++) begin
                txd[k] = 8'($urandom);
                txm[k] = 1'($urandom);
            end
            read_txn(len, 1'b0, 1'b1);
            if ($urandom % 2 == 0) begin
                m_stop();
                chk("R9 tx_done after STOP (random)", tx_done, 1'b1);
            end else begin
                m_start();
                send_addr(ME ^ 7'h40, 1'b1, ackbit);
                chk("R10 foreign restart not acked (random)", ackbit, 1'b1);
                chk("R10 tx_done after foreign restart (random)", tx_done, 1'b1);
                m_stop();
            end
            chk("R11 idle flags after STOP", {slv_access, slv_read, clk_wait}, 3'b000);
        end

        summary();
        $finish;
    end

endmodule